// File: doc/BRIEF.md
# ADC Conversion Step Sequencer

This block drives a successive-approximation converter through a table of up to sixteen conversion steps. Every step carries its own settings: an enable, an input channel, a start offset (the open delay), an acquisition width (the sample delay) and an averaging code. After a run request the sequencer visits the enabled steps in ascending index order. For each step it drives the channel select, waits out the open delay, holds the acquisition strobe for the programmed width and then pulses start-of-conversion. It then waits for the converter to report a result.

When a step asks for averaging, acquisition and conversion repeat until the programmed number of results has been summed. The sum is then scaled down and offered on a valid/ready output, together with the index of the step that produced it. A mode input chooses what happens after the last enabled step: stop, or start over from the lowest enabled step. All timing is counted in cycles of the converter clock that drives the block.

Top module: `adc_step_seq`

## Requirements
- R1: Enabled steps (bit i of `stepEnable` enables step i) run in ascending index order and disabled steps are skipped. A run request with no step enabled leaves the sequencer idle.
- R2: A step starts in the first cycle that `resStep` shows its index with `seqBusy` high. `sampleOut` rises exactly N cycles after that cycle, where N is the step's open-delay field. N = 0 means the same cycle.
- R3: Each acquisition holds `sampleOut` high for exactly S + 2 consecutive cycles, where S is the step's sample-delay field (0 to 255).
- R4: `socOut` is a single-cycle pulse in the cycle right after `sampleOut` falls, and the two are never high together.
- R5: After start-of-conversion the sequencer waits for `convDone`. An averaging step repeats acquisition and conversion, without a new open delay, until it has collected its count of results. A `convDone` that arrives while no conversion is awaited is ignored.
- R6: Averaging code c (3 bits) selects 2^c conversions for c = 0..4, and codes 5 to 7 select 16. The result is the 16-bit sum of the 12-bit conversion values shifted right by min(c, 4).
- R7: The result is offered with `resValid` and carries its step index on `resStep`. While `resValid` is high and `resReady` is low, `resData` and `resStep` hold, and no acquisition or conversion starts.
- R8: With `contMode` low the sequencer returns to idle (`seqBusy` low) after the last enabled step is accepted. With `contMode` high it restarts from the lowest enabled step.
- R9: After reset the sequencer is idle: `seqBusy`, `sampleOut`, `socOut` and `resValid` are low and `resStep` is 0.
- R10: `chanSel` equals the channel field of the current step whenever `sampleOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runStart | input | 1 | Start a pass when idle |
| contMode | input | 1 | 1: restart after the last enabled step |
| stepEnable | input | 16 | Per-step enable |
| stepChan | input | 48 | Per-step channel, 3 bits each, step i at bits [3i+2:3i] |
| stepOpen | input | 288 | Per-step open delay, 18 bits each |
| stepSamp | input | 128 | Per-step sample delay, 8 bits each |
| stepAvg | input | 48 | Per-step averaging code, 3 bits each |
| chanSel | output | 3 | Input channel for the current step |
| sampleOut | output | 1 | Acquisition strobe |
| socOut | output | 1 | Start-of-conversion pulse |
| convDone | input | 1 | Converter result strobe |
| convData | input | 12 | Converter result value |
| resValid | output | 1 | Averaged result available |
| resReady | input | 1 | Result accepted |
| resData | output | 12 | Averaged result |
| resStep | output | 4 | Step index of the current or offered result |
| seqBusy | output | 1 | Sequencer not idle |

## Verification
Two things can land on the converter handshake in the same cycle range: the sequencer counting out a step's open delay, and a result strobe from the converter. The bench provokes this by injecting a `convDone` with full-scale data a few cycles into a 25-cycle open delay. It then judges the averaged output against a sum built only from the converter model's own answers. A second collision is a stalled result while continuous mode wants to wrap. The bench holds `resReady` low for several cycles and requires the output to stay frozen and the acquisition strobe to stay quiet until the handshake.

// File: rtl/adc_step_seq_pkg.sv
package adc_step_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_ACQ,
    S_SOC,
    S_WAIT,
    S_EMIT
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic startStep;  // load a new step index and its first delay
    logic fromFirst;  // new step is the lowest enabled one (wrap / run)
    logic loadAcq;    // load the acquisition width of the current step
    logic decCnt;     // count down the delay counter
    logic addConv;    // add the converter value to the accumulator
  } seqCtlT;

  // status from datapath to control
  typedef struct packed {
    logic firstFound;
    logic firstOpenZero;
    logic upFound;
    logic upOpenZero;
    logic cntLast;
    logic avgLast;
  } seqStatT;

endpackage

// File: rtl/adc_step_seq_dp.sv
module adc_step_seq_dp
  import adc_step_seq_pkg::*;
#(
  parameter int NUM_STEPS    = 16,
  parameter int CHAN_W       = 3,
  parameter int OPEN_W       = 18,
  parameter int SAMP_W       = 8,
  parameter int AVG_W        = 3,
  parameter int DATA_W       = 12,
  parameter int MAX_AVG_LOG2 = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqCtlT                      ctl,
  output seqStatT                     stat,
  input  logic [NUM_STEPS-1:0]        stepEnable,
  input  logic [NUM_STEPS*CHAN_W-1:0] stepChan,
  input  logic [NUM_STEPS*OPEN_W-1:0] stepOpen,
  input  logic [NUM_STEPS*SAMP_W-1:0] stepSamp,
  input  logic [NUM_STEPS*AVG_W-1:0]  stepAvg,
  input  logic [DATA_W-1:0]           convData,
  output logic [CHAN_W-1:0]           chanSel,
  output logic [DATA_W-1:0]           resData,
  output logic [$clog2(NUM_STEPS)-1:0] resStep
);

  localparam int IDX_W = $clog2(NUM_STEPS);
  localparam int ACC_W = DATA_W + MAX_AVG_LOG2;
  localparam int CNT_W = MAX_AVG_LOG2 + 1;

  logic [CHAN_W-1:0] chanA [NUM_STEPS];
  logic [OPEN_W-1:0] openA [NUM_STEPS];
  logic [SAMP_W-1:0] sampA [NUM_STEPS];
  logic [AVG_W-1:0]  avgA  [NUM_STEPS];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_unpack
    assign chanA[g] = stepChan[g*CHAN_W +: CHAN_W];
    assign openA[g] = stepOpen[g*OPEN_W +: OPEN_W];
    assign sampA[g] = stepSamp[g*SAMP_W +: SAMP_W];
    assign avgA[g]  = stepAvg[g*AVG_W +: AVG_W];
  end

  logic [IDX_W-1:0]  stepIdx;
  logic [OPEN_W-1:0] cnt;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  convCnt;

  logic [IDX_W-1:0]  firstIdx, upIdx, newIdx;
  logic              firstFound, upFound;

  // lowest enabled step overall, and lowest enabled step above the current
  always_comb begin
    firstIdx   = '0;
    firstFound = 1'b0;
    upIdx      = '0;
    upFound    = 1'b0;
    for (int i = NUM_STEPS - 1; i >= 0; i--) begin
      if (stepEnable[i]) begin
        firstIdx   = IDX_W'(i);
        firstFound = 1'b1;
        if (IDX_W'(i) > stepIdx) begin
          upIdx   = IDX_W'(i);
          upFound = 1'b1;
        end
      end
    end
  end

  assign newIdx = ctl.fromFirst ? firstIdx : upIdx;

  logic [OPEN_W-1:0] acqCur, acqNew, startLoad;
  assign acqCur    = OPEN_W'(sampA[stepIdx]) + OPEN_W'(2);
  assign acqNew    = OPEN_W'(sampA[newIdx]) + OPEN_W'(2);
  assign startLoad = (openA[newIdx] != '0) ? openA[newIdx] : acqNew;

  logic [AVG_W-1:0] codeC;
  logic [CNT_W-1:0] lastCnt;
  assign codeC   = (avgA[stepIdx] > AVG_W'(MAX_AVG_LOG2)) ? AVG_W'(MAX_AVG_LOG2) : avgA[stepIdx];
  assign lastCnt = (CNT_W'(1) << codeC) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
      cnt     <= '0;
      acc     <= '0;
      convCnt <= '0;
    end else if (ctl.startStep) begin
      stepIdx <= newIdx;
      cnt     <= startLoad;
      acc     <= '0;
      convCnt <= '0;
    end else begin
      if (ctl.loadAcq)      cnt <= acqCur;
      else if (ctl.decCnt)  cnt <= cnt - OPEN_W'(1);
      if (ctl.addConv) begin
        acc     <= acc + ACC_W'(convData);
        convCnt <= convCnt + CNT_W'(1);
      end
    end
  end

  assign stat.firstFound    = firstFound;
  assign stat.firstOpenZero = (openA[firstIdx] == '0);
  assign stat.upFound       = upFound;
  assign stat.upOpenZero    = (openA[upIdx] == '0);
  assign stat.cntLast       = (cnt == OPEN_W'(1));
  assign stat.avgLast       = (convCnt == lastCnt);

  assign chanSel = chanA[stepIdx];
  assign resData = DATA_W'(acc >> codeC);
  assign resStep = stepIdx;

endmodule

// File: rtl/adc_step_seq_ctrl.sv
module adc_step_seq_ctrl
  import adc_step_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runStart,
  input  logic    contMode,
  input  logic    convDone,
  input  logic    resReady,
  input  seqStatT stat,
  output seqCtlT  ctl,
  output logic    sampleOut,
  output logic    socOut,
  output logic    resValid,
  output logic    seqBusy
);

  seqStateT state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (runStart && stat.firstFound) begin
          ctl.startStep = 1'b1;
          ctl.fromFirst = 1'b1;
          stateNext     = stat.firstOpenZero ? S_ACQ : S_OPEN;
        end
      end
      S_OPEN: begin
        if (stat.cntLast) begin
          ctl.loadAcq = 1'b1;
          stateNext   = S_ACQ;
        end else begin
          ctl.decCnt = 1'b1;
        end
      end
      S_ACQ: begin
        if (stat.cntLast) stateNext = S_SOC;
        else              ctl.decCnt = 1'b1;
      end
      S_SOC: stateNext = S_WAIT;
      S_WAIT: begin
        if (convDone) begin
          ctl.addConv = 1'b1;
          if (stat.avgLast) begin
            stateNext = S_EMIT;
          end else begin
            ctl.loadAcq = 1'b1;
            stateNext   = S_ACQ;
          end
        end
      end
      S_EMIT: begin
        if (resReady) begin
          if (stat.upFound) begin
            ctl.startStep = 1'b1;
            stateNext     = stat.upOpenZero ? S_ACQ : S_OPEN;
          end else if (contMode && stat.firstFound) begin
            ctl.startStep = 1'b1;
            ctl.fromFirst = 1'b1;
            stateNext     = stat.firstOpenZero ? S_ACQ : S_OPEN;
          end else begin
            stateNext = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign sampleOut = (state == S_ACQ);
  assign socOut    = (state == S_SOC);
  assign resValid  = (state == S_EMIT);
  assign seqBusy   = (state != S_IDLE);

endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_step_seq_pkg::*;
#(
  parameter int NUM_STEPS    = 16,
  parameter int CHAN_W       = 3,
  parameter int OPEN_W       = 18,
  parameter int SAMP_W       = 8,
  parameter int AVG_W        = 3,
  parameter int DATA_W       = 12,
  parameter int MAX_AVG_LOG2 = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         runStart,
  input  logic                         contMode,
  input  logic [NUM_STEPS-1:0]         stepEnable,
  input  logic [NUM_STEPS*CHAN_W-1:0]  stepChan,
  input  logic [NUM_STEPS*OPEN_W-1:0]  stepOpen,
  input  logic [NUM_STEPS*SAMP_W-1:0]  stepSamp,
  input  logic [NUM_STEPS*AVG_W-1:0]   stepAvg,
  output logic [CHAN_W-1:0]            chanSel,
  output logic                         sampleOut,
  output logic                         socOut,
  input  logic                         convDone,
  input  logic [DATA_W-1:0]            convData,
  output logic                         resValid,
  input  logic                         resReady,
  output logic [DATA_W-1:0]            resData,
  output logic [$clog2(NUM_STEPS)-1:0] resStep,
  output logic                         seqBusy
);

  seqCtlT  ctl;
  seqStatT stat;

  adc_step_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .runStart  (runStart),
    .contMode  (contMode),
    .convDone  (convDone),
    .resReady  (resReady),
    .stat      (stat),
    .ctl       (ctl),
    .sampleOut (sampleOut),
    .socOut    (socOut),
    .resValid  (resValid),
    .seqBusy   (seqBusy)
  );

  adc_step_seq_dp #(
    .NUM_STEPS    (NUM_STEPS),
    .CHAN_W       (CHAN_W),
    .OPEN_W       (OPEN_W),
    .SAMP_W       (SAMP_W),
    .AVG_W        (AVG_W),
    .DATA_W       (DATA_W),
    .MAX_AVG_LOG2 (MAX_AVG_LOG2)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .stat       (stat),
    .stepEnable (stepEnable),
    .stepChan   (stepChan),
    .stepOpen   (stepOpen),
    .stepSamp   (stepSamp),
    .stepAvg    (stepAvg),
    .convData   (convData),
    .chanSel    (chanSel),
    .resData    (resData),
    .resStep    (resStep)
  );

endmodule

// File: rtl/adc_step_seq_sva.sv
module adc_step_seq_sva #(
  parameter int NUM_STEPS = 16,
  parameter int SAMP_W    = 8,
  parameter int DATA_W    = 12
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sampleOut,
  input logic                         socOut,
  input logic                         resValid,
  input logic                         resReady,
  input logic [DATA_W-1:0]            resData,
  input logic [$clog2(NUM_STEPS)-1:0] resStep,
  input logic                         seqBusy,
  input logic [NUM_STEPS*SAMP_W-1:0]  stepSamp
);

  localparam int LEN_W = SAMP_W + 2;

  logic [LEN_W-1:0]  acqLen;
  logic [SAMP_W-1:0] sampVal;

  assign sampVal = stepSamp[int'(resStep)*SAMP_W +: SAMP_W];

  // length of the current / just-finished acquisition strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          acqLen <= '0;
    else if (sampleOut) acqLen <= acqLen + LEN_W'(1);
    else                acqLen <= '0;
  end

  p_acq_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleOut && acqLen != '0) |-> (acqLen == LEN_W'(sampVal) + LEN_W'(2)));

  p_soc_after_acq_r4: assert property (@(posedge clk) disable iff (!rstN)
    socOut |-> ($past(sampleOut) && !sampleOut));

  p_soc_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    socOut |=> !socOut);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData) && $stable(resStep)));

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (!sampleOut && !socOut));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seqBusy |-> (!sampleOut && !socOut && !resValid));

endmodule

bind adc_step_seq adc_step_seq_sva #(
  .NUM_STEPS (NUM_STEPS),
  .SAMP_W    (SAMP_W),
  .DATA_W    (DATA_W)
) sva_i (
  .clk       (clk),
  .rstN      (rstN),
  .sampleOut (sampleOut),
  .socOut    (socOut),
  .resValid  (resValid),
  .resReady  (resReady),
  .resData   (resData),
  .resStep   (resStep),
  .seqBusy   (seqBusy),
  .stepSamp  (stepSamp)
);

// File: tb/adc_step_seq_tb_top.sv
`timescale 1ns/1ps
module adc_step_seq_tb_top;

  localparam int NS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              runStart = 1'b0;
  logic              contMode = 1'b0;
  logic              resReady = 1'b1;
  logic [NS-1:0]     stepEnable;
  logic [NS*3-1:0]   stepChan;
  logic [NS*18-1:0]  stepOpen;
  logic [NS*8-1:0]   stepSamp;
  logic [NS*3-1:0]   stepAvg;
  logic [2:0]        chanSel;
  logic              sampleOut, socOut, resValid, seqBusy;
  logic [11:0]       resData;
  logic [3:0]        resStep;
  logic              convDone;
  logic [11:0]       convData;

  logic              en [NS];
  logic [2:0]        ch [NS];
  logic [17:0]       od [NS];
  logic [7:0]        sd [NS];
  logic [2:0]        av [NS];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      stepEnable[i]       = en[i];
      stepChan[i*3 +: 3]  = ch[i];
      stepOpen[i*18 +: 18] = od[i];
      stepSamp[i*8 +: 8]  = sd[i];
      stepAvg[i*3 +: 3]   = av[i];
    end
  end

  // converter model and spurious strobe
  logic        mDone = 1'b0;
  logic [11:0] mData = '0;
  logic        spur  = 1'b0;
  assign convDone = mDone | spur;
  assign convData = spur ? 12'hFFF : mData;

  adc_step_seq dut_i (
    .clk(clk), .rstN(rstN), .runStart(runStart), .contMode(contMode),
    .stepEnable(stepEnable), .stepChan(stepChan), .stepOpen(stepOpen),
    .stepSamp(stepSamp), .stepAvg(stepAvg), .chanSel(chanSel),
    .sampleOut(sampleOut), .socOut(socOut), .convDone(convDone),
    .convData(convData), .resValid(resValid), .resReady(resReady),
    .resData(resData), .resStep(resStep), .seqBusy(seqBusy)
  );

  int checks = 0;
  int errs   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor state (negedge sampling)
  int  ncyc = 0, startCyc = 0, acqLen = 0, latCnt = 0, convNum = 0;
  int  modelSum = 0, modelN = 0;
  int  nextVal = 0;
  bit  prevBusy = 0, prevSample = 0, firstAcq = 0;
  logic [3:0] prevStep = '0;
  int  resCount = 0;
  int  stepLog [64];
  int  dataLog [64];

  function automatic int clampCode(input int c);
    return (c > 4) ? 4 : c;
  endfunction

  always @(negedge clk) begin
    ncyc++;
    // converter model: answer 3 cycles after start-of-conversion
    mDone = 1'b0;
    if (latCnt != 0) begin
      latCnt--;
      if (latCnt == 0) begin
        mDone = 1'b1;
        mData = 12'(nextVal);
        modelSum += nextVal;
        modelN++;
        convNum++;
      end
    end
    if (socOut) begin
      latCnt  = 3;
      nextVal = (int'(chanSel) * 500 + convNum * 37 + 11) % 4096;
    end
    if (rstN) begin
      // step start and open delay (R2), channel (R10)
      if (seqBusy && (!prevBusy || resStep != prevStep)) begin
        startCyc = ncyc;
        firstAcq = 1;
      end
      if (sampleOut && !prevSample) begin
        if (firstAcq) chk((ncyc - startCyc) == int'(od[resStep]), "R2 open delay", ncyc - startCyc, int'(od[resStep]));
        firstAcq = 0;
        chk(chanSel == ch[resStep], "R10 channel", int'(chanSel), int'(ch[resStep]));
        acqLen = 0;
      end
      if (sampleOut) acqLen++;
      if (!sampleOut && prevSample) begin
        chk(acqLen == int'(sd[resStep]) + 2, "R3 window", acqLen, int'(sd[resStep]) + 2);
        chk(socOut, "R4 soc follows", int'(socOut), 1);
      end
      if (sampleOut && socOut) chk(0, "R4 overlap", 1, 0);
      // result handshake (R6, R5)
      if (resValid && resReady) begin
        chk(int'(resData) == (modelSum >> clampCode(int'(av[resStep]))), "R6 average",
            int'(resData), modelSum >> clampCode(int'(av[resStep])));
        chk(modelN == (1 << clampCode(int'(av[resStep]))), "R5 conversion count",
            modelN, 1 << clampCode(int'(av[resStep])));
        if (resCount < 64) begin
          stepLog[resCount] = int'(resStep);
          dataLog[resCount] = int'(resData);
        end
        resCount++;
        modelSum = 0;
        modelN   = 0;
      end
    end
    prevBusy   = seqBusy;
    prevStep   = resStep;
    prevSample = sampleOut;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic clearCfg();
    for (int i = 0; i < NS; i++) begin
      en[i] = 0; ch[i] = '0; od[i] = '0; sd[i] = '0; av[i] = '0;
    end
  endtask

  task automatic setStep(input int i, input int c, input int o, input int s, input int a);
    en[i] = 1; ch[i] = 3'(c); od[i] = 18'(o); sd[i] = 8'(s); av[i] = 3'(a);
  endtask

  task automatic pulseRun();
    @(negedge clk) runStart = 1'b1;
    @(negedge clk) runStart = 1'b0;
  endtask

  task automatic waitIdle(input int maxCyc);
    int n = 0;
    repeat (3) @(negedge clk);
    while (seqBusy && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!seqBusy && !sampleOut && !socOut && !resValid, "R9 reset idle",
        int'({seqBusy, sampleOut, socOut, resValid}), 0);
    chk(resStep == 4'd0, "R9 reset step", int'(resStep), 0);
  endtask

  task automatic t_oneshot_mix();
    int base = resCount;
    int want [4] = '{1, 3, 4, 9};
    clearCfg();
    setStep(1, 5, 0, 0, 0);
    setStep(3, 2, 7, 3, 2);
    setStep(4, 7, 1, 255, 1);
    setStep(9, 0, 1000, 12, 4);
    pulseRun();
    waitIdle(20000);
    chk(resCount - base == 4, "R1 result count", resCount - base, 4);
    for (int k = 0; k < 4; k++)
      chk(stepLog[base + k] == want[k], "R1 step order", stepLog[base + k], want[k]);
    repeat (10) @(negedge clk);
    chk(!seqBusy && !sampleOut, "R8 one-shot stops", int'(seqBusy), 0);
  endtask

  task automatic t_avg_clamp();
    int base = resCount;
    clearCfg();
    setStep(0, 3, 3, 1, 7);
    setStep(15, 6, 0, 4, 3);
    pulseRun();
    waitIdle(20000);
    chk(resCount - base == 2, "R6 clamp results", resCount - base, 2);
    chk(stepLog[base + 1] == 15, "R1 last step", stepLog[base + 1], 15);
    chk(!seqBusy, "R8 stop after step 15", int'(seqBusy), 0);
  endtask

  task automatic t_spurious_done();
    int base = resCount;
    clearCfg();
    setStep(8, 4, 25, 2, 1);
    pulseRun();
    repeat (5) @(negedge clk);
    spur = 1'b1;
    @(negedge clk) spur = 1'b0;
    chk(!sampleOut && !resValid, "R5 spurious ignored in open delay", int'(sampleOut), 0);
    waitIdle(5000);
    chk(resCount - base == 1, "R5 single result", resCount - base, 1);
    chk(dataLog[base] != 12'hFFF, "R5 spurious value absent", dataLog[base], 0);
  endtask

  task automatic t_stall();
    logic [11:0] cap;
    int n = 0;
    clearCfg();
    setStep(6, 1, 2, 4, 2);
    resReady = 1'b0;
    pulseRun();
    while (!resValid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    cap = resData;
    chk(resStep == 4'd6, "R7 step tag", int'(resStep), 6);
    repeat (6) begin
      @(negedge clk);
      chk(resValid && resData == cap && !sampleOut && !socOut, "R7 stall hold",
          int'(resData), int'(cap));
    end
    resReady = 1'b1;
    waitIdle(2000);
    chk(!seqBusy, "R7 released", int'(seqBusy), 0);
  endtask

  task automatic t_continuous();
    int base = resCount;
    int want [4] = '{2, 5, 2, 5};
    int n = 0;
    clearCfg();
    setStep(2, 3, 4, 1, 0);
    setStep(5, 7, 0, 2, 1);
    contMode = 1'b1;
    pulseRun();
    while (resCount < base + 3 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    contMode = 1'b0;
    waitIdle(5000);
    chk(resCount - base == 4, "R8 wrap count", resCount - base, 4);
    for (int k = 0; k < 4; k++)
      chk(stepLog[base + k] == want[k], "R8 wrap order", stepLog[base + k], want[k]);
  endtask

  task automatic t_none_enabled();
    clearCfg();
    pulseRun();
    repeat (5) begin
      @(negedge clk);
      chk(!seqBusy && !sampleOut, "R1 nothing enabled", int'(seqBusy), 0);
    end
  endtask

  initial begin
    clearCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_oneshot_mix();
    t_avg_clamp();
    t_spurious_done();
    t_stall();
    t_continuous();
    t_none_enabled();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule